// File: doc/BRIEF.md
# Vsync-Latched Shadow Register Bank

This block holds the per-window configuration of a display controller that composes several overlay windows. Software reaches it through a plain write port and a read port with one cycle of latency. Every window register exists twice. The shadow copy takes each write at once. The active copy drives the display pipeline and changes only on a vertical sync pulse. A new frame therefore never starts on a half-written window setup.

A transfer from shadow to active needs two things: a request that software arms through the trigger register, and a vsync pulse. Software can hold a multi-word update for any window by setting that window's protect bit. A protected window keeps its request pending across vsync pulses. The window moves at the first vsync after the bit is released. The window enable is bit 0 of each window's control word, so turning a window on or off also waits for a vsync.

Top module: `vsync_shadow_regs`

## Requirements
- R1: A synchronous reset clears every shadow and active word, every protect bit and every pending request, so all windows start disabled and unprotected.
- R2: Word k of window w lives at address w*REGS_PER_WIN+k. A write lands in its shadow word at once. A read returns the shadow value with rd_valid_o one cycle after rd_en_i. The active outputs do not change.
- R3: On a vsync pulse, each window that has a pending request and is not protected copies all of its shadow words into its active words. The new values appear on act_regs_o from the next cycle.
- R4: A vsync pulse with no pending request for a window leaves that window's active words unchanged, and without vsync no active word ever changes.
- R5: A window whose protect bit is set at the vsync pulse is not copied, and its pending request is kept. Unprotected windows are still copied by the same pulse. The protect register sits at address NUM_WIN*REGS_PER_WIN and has one bit per window, bit w for window w.
- R6: Once a protect bit is cleared, the held shadow values of that window reach the active copy at the next vsync pulse.
- R7: act_en_o[w] follows bit 0 of window w's active control word (word 0). Clearing that bit in the shadow keeps the window enabled until a vsync transfer.
- R8: Writing 1 to bit 0 of the trigger register (address NUM_WIN*REGS_PER_WIN+1) marks every window pending. Each window's pending bit clears by itself when that window is transferred. Reading the trigger address returns the pending bits, bit w for window w.
- R9: Reading the status address (NUM_WIN*REGS_PER_WIN+2) returns the active enables, bit w for window w.
- R10: When a shadow write and a transferring vsync fall in the same cycle, the active copy takes the value from before the write and the shadow keeps the new value.
- R11: A trigger write in the same cycle as a vsync pulse is not consumed by that pulse. The request stays pending for the next vsync.
- R12: Writes to the status address or to any address above it are ignored. Reads of addresses above the status address return zero.
- R13: A protect write in the same cycle as a vsync pulse does not affect that pulse, which uses the protect bits held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Write word address |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read word address |
| rd_valid_o | output | 1 | Read data valid (one cycle after rd_en_i) |
| rd_data_o | output | DATA_W | Read data |
| vsync_i | input | 1 | Single-cycle vertical sync pulse |
| act_regs_o | output | NUM_WIN*REGS_PER_WIN*DATA_W | All active words, window w word k at bit (w*REGS_PER_WIN+k)*DATA_W |
| act_en_o | output | NUM_WIN | Active enable of each window |

## Verification
The vsync transfer can fall in the same cycle as a software write to a shadow word, to the trigger register or to the protect register. The bench drives each of these pairs on purpose: a window word together with a vsync pulse, a trigger together with a vsync pulse, and a protect change together with a vsync pulse. The behavioural model then decides which value each side must see. The active copy must hold the old shadow word while the shadow holds the new one. A request raised in the collision cycle must survive the pulse. The pulse must obey the protect bits held before the write. A random phase follows that throws these collisions together with reads at a high rate, and every cycle is compared against the model.

// File: rtl/vsr_pkg.sv
`timescale 1ns/1ps
package vsr_pkg;
   typedef enum logic [2:0] {
      ACC_NONE = 3'd0,
      ACC_WIN  = 3'd1,
      ACC_PROT = 3'd2,
      ACC_TRIG = 3'd3,
      ACC_STAT = 3'd4
   } vsr_acc_e;
endpackage

// File: rtl/vsr_decode.sv
`timescale 1ns/1ps
module vsr_decode
   import vsr_pkg::*;
#(
   parameter int NUM_WIN      = 2,
   parameter int REGS_PER_WIN = 4,
   parameter int ADDR_W       = 4
)(
   input  logic [ADDR_W-1:0]                 addr_i,
   output vsr_acc_e                          kind_o,
   output logic [$clog2(NUM_WIN)-1:0]        win_o,
   output logic [$clog2(REGS_PER_WIN)-1:0]   idx_o
);
   localparam int IDX_W  = $clog2(REGS_PER_WIN);
   localparam int WSEL_W = $clog2(NUM_WIN);
   localparam int SPAN   = NUM_WIN * REGS_PER_WIN;
   localparam logic [ADDR_W-1:0] PROT_A = ADDR_W'(SPAN);
   localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(SPAN + 1);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(SPAN + 2);

   assign idx_o = addr_i[IDX_W-1:0];
   assign win_o = addr_i[IDX_W +: WSEL_W];

   always_comb begin
      if (addr_i < PROT_A)       kind_o = ACC_WIN;
      else if (addr_i == PROT_A) kind_o = ACC_PROT;
      else if (addr_i == TRIG_A) kind_o = ACC_TRIG;
      else if (addr_i == STAT_A) kind_o = ACC_STAT;
      else                       kind_o = ACC_NONE;
   end
endmodule

// File: rtl/vsr_window.sv
`timescale 1ns/1ps
module vsr_window #(
   parameter int REGS_PER_WIN = 4,
   parameter int DATA_W       = 32
)(
   input  logic                              clk_i,
   input  logic                              rst_i,
   input  logic                              we_i,
   input  logic [$clog2(REGS_PER_WIN)-1:0]   idx_i,
   input  logic [DATA_W-1:0]                 data_i,
   input  logic                              xfer_i,
   output logic [REGS_PER_WIN*DATA_W-1:0]    shadow_o,
   output logic [REGS_PER_WIN*DATA_W-1:0]    active_o
);
   logic [DATA_W-1:0] sh_q [REGS_PER_WIN];
   logic [DATA_W-1:0] ac_q [REGS_PER_WIN];

   // the copy reads the shadow before this cycle's write lands
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         for (int k = 0; k < REGS_PER_WIN; k++) begin
            sh_q[k] <= '0;
            ac_q[k] <= '0;
         end
      end else begin
         if (xfer_i) begin
            for (int k = 0; k < REGS_PER_WIN; k++) ac_q[k] <= sh_q[k];
         end
         if (we_i) sh_q[idx_i] <= data_i;
      end
   end

   for (genvar k = 0; k < REGS_PER_WIN; k++) begin : g_flat
      assign shadow_o[k*DATA_W +: DATA_W] = sh_q[k];
      assign active_o[k*DATA_W +: DATA_W] = ac_q[k];
   end
endmodule

// File: rtl/vsr_xfer_ctrl.sv
`timescale 1ns/1ps
module vsr_xfer_ctrl #(
   parameter int NUM_WIN = 2
)(
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               vsync_i,
   input  logic               prot_we_i,
   input  logic [NUM_WIN-1:0] prot_data_i,
   input  logic               trig_we_i,
   output logic [NUM_WIN-1:0] prot_o,
   output logic [NUM_WIN-1:0] pend_o,
   output logic [NUM_WIN-1:0] xfer_o
);
   logic [NUM_WIN-1:0] prot_q, pend_q;

   assign xfer_o = {NUM_WIN{vsync_i}} & pend_q & ~prot_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         prot_q <= '0;
         pend_q <= '0;
      end else begin
         if (prot_we_i) prot_q <= prot_data_i;
         pend_q <= (pend_q & ~xfer_o) | {NUM_WIN{trig_we_i}};
      end
   end

   assign prot_o = prot_q;
   assign pend_o = pend_q;
endmodule

// File: rtl/vsr_read_mux.sv
`timescale 1ns/1ps
module vsr_read_mux
   import vsr_pkg::*;
#(
   parameter int NUM_WIN      = 2,
   parameter int REGS_PER_WIN = 4,
   parameter int DATA_W       = 32,
   parameter int READ_LAT     = 1
)(
   input  logic                                      clk_i,
   input  logic                                      rst_i,
   input  logic                                      rd_en_i,
   input  vsr_acc_e                                  kind_i,
   input  logic [$clog2(NUM_WIN)-1:0]                win_i,
   input  logic [$clog2(REGS_PER_WIN)-1:0]           idx_i,
   input  logic [NUM_WIN*REGS_PER_WIN*DATA_W-1:0]    shadow_i,
   input  logic [NUM_WIN-1:0]                        prot_i,
   input  logic [NUM_WIN-1:0]                        pend_i,
   input  logic [NUM_WIN-1:0]                        act_en_i,
   output logic                                      rd_valid_o,
   output logic [DATA_W-1:0]                         rd_data_o
);
   localparam int SPAN = NUM_WIN * REGS_PER_WIN;

   logic [DATA_W-1:0] words [SPAN];
   logic [DATA_W-1:0] sel;

   for (genvar i = 0; i < SPAN; i++) begin : g_words
      assign words[i] = shadow_i[i*DATA_W +: DATA_W];
   end

   always_comb begin
      case (kind_i)
         ACC_WIN:  sel = words[{win_i, idx_i}];
         ACC_PROT: sel = DATA_W'(prot_i);
         ACC_TRIG: sel = DATA_W'(pend_i);
         ACC_STAT: sel = DATA_W'(act_en_i);
         default:  sel = '0;
      endcase
   end

   if (READ_LAT == 0) begin : g_comb
      assign rd_valid_o = rd_en_i;
      assign rd_data_o  = sel;
   end else begin : g_reg
      logic              vld_q;
      logic [DATA_W-1:0] dat_q;
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            vld_q <= 1'b0;
            dat_q <= '0;
         end else begin
            vld_q <= rd_en_i;
            if (rd_en_i) dat_q <= sel;
         end
      end
      assign rd_valid_o = vld_q;
      assign rd_data_o  = dat_q;
   end
endmodule

// File: rtl/vsync_shadow_regs.sv
`timescale 1ns/1ps
module vsync_shadow_regs
   import vsr_pkg::*;
#(
   parameter int NUM_WIN      = 2,
   parameter int REGS_PER_WIN = 4,
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 4,
   parameter int READ_LAT     = 1,
   parameter int EN_BIT       = 0
)(
   input  logic                                   clk_i,
   input  logic                                   rst_i,
   input  logic                                   wr_en_i,
   input  logic [ADDR_W-1:0]                      wr_addr_i,
   input  logic [DATA_W-1:0]                      wr_data_i,
   input  logic                                   rd_en_i,
   input  logic [ADDR_W-1:0]                      rd_addr_i,
   output logic                                   rd_valid_o,
   output logic [DATA_W-1:0]                      rd_data_o,
   input  logic                                   vsync_i,
   output logic [NUM_WIN*REGS_PER_WIN*DATA_W-1:0] act_regs_o,
   output logic [NUM_WIN-1:0]                     act_en_o
);
   localparam int IDX_W  = $clog2(REGS_PER_WIN);
   localparam int WSEL_W = $clog2(NUM_WIN);
   localparam int WIN_W  = REGS_PER_WIN * DATA_W;
   localparam int TOT_W  = NUM_WIN * WIN_W;

   if (NUM_WIN < 2) begin : g_chk_win
      $error("NUM_WIN must be at least 2");
   end
   if (REGS_PER_WIN < 2 || (REGS_PER_WIN & (REGS_PER_WIN - 1)) != 0) begin : g_chk_rpw
      $error("REGS_PER_WIN must be a power of two, at least 2");
   end
   if ((1 << ADDR_W) < NUM_WIN * REGS_PER_WIN + 3) begin : g_chk_addr
      $error("ADDR_W too narrow for the address map");
   end
   if (DATA_W < NUM_WIN || EN_BIT >= DATA_W) begin : g_chk_data
      $error("DATA_W too narrow");
   end
   if (READ_LAT != 0 && READ_LAT != 1) begin : g_chk_lat
      $error("READ_LAT must be 0 or 1");
   end

   vsr_acc_e             w_kind, r_kind;
   logic [WSEL_W-1:0]    w_win, r_win;
   logic [IDX_W-1:0]     w_idx, r_idx;
   logic [TOT_W-1:0]     shadow_all;
   logic [NUM_WIN-1:0]   prot_q, pend_q, xfer;
   logic                 prot_we, trig_we;

   vsr_decode #(.NUM_WIN(NUM_WIN), .REGS_PER_WIN(REGS_PER_WIN), .ADDR_W(ADDR_W))
      u_wdec (.addr_i(wr_addr_i), .kind_o(w_kind), .win_o(w_win), .idx_o(w_idx));

   vsr_decode #(.NUM_WIN(NUM_WIN), .REGS_PER_WIN(REGS_PER_WIN), .ADDR_W(ADDR_W))
      u_rdec (.addr_i(rd_addr_i), .kind_o(r_kind), .win_o(r_win), .idx_o(r_idx));

   assign prot_we = wr_en_i && (w_kind == ACC_PROT);
   assign trig_we = wr_en_i && (w_kind == ACC_TRIG) && wr_data_i[0];

   vsr_xfer_ctrl #(.NUM_WIN(NUM_WIN)) u_ctrl (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .vsync_i     (vsync_i),
      .prot_we_i   (prot_we),
      .prot_data_i (wr_data_i[NUM_WIN-1:0]),
      .trig_we_i   (trig_we),
      .prot_o      (prot_q),
      .pend_o      (pend_q),
      .xfer_o      (xfer)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      logic we;
      assign we = wr_en_i && (w_kind == ACC_WIN) && (w_win == WSEL_W'(w));
      vsr_window #(.REGS_PER_WIN(REGS_PER_WIN), .DATA_W(DATA_W)) u_win (
         .clk_i    (clk_i),
         .rst_i    (rst_i),
         .we_i     (we),
         .idx_i    (w_idx),
         .data_i   (wr_data_i),
         .xfer_i   (xfer[w]),
         .shadow_o (shadow_all[w*WIN_W +: WIN_W]),
         .active_o (act_regs_o[w*WIN_W +: WIN_W])
      );
      assign act_en_o[w] = act_regs_o[w*WIN_W + EN_BIT];
   end

   vsr_read_mux #(.NUM_WIN(NUM_WIN), .REGS_PER_WIN(REGS_PER_WIN),
                  .DATA_W(DATA_W), .READ_LAT(READ_LAT)) u_rmux (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .rd_en_i    (rd_en_i),
      .kind_i     (r_kind),
      .win_i      (r_win),
      .idx_i      (r_idx),
      .shadow_i   (shadow_all),
      .prot_i     (prot_q),
      .pend_i     (pend_q),
      .act_en_i   (act_en_o),
      .rd_valid_o (rd_valid_o),
      .rd_data_o  (rd_data_o)
   );
endmodule

// File: rtl/vsr_checker.sv
`timescale 1ns/1ps
module vsr_checker #(
   parameter int NUM_WIN      = 2,
   parameter int REGS_PER_WIN = 4,
   parameter int DATA_W       = 32,
   parameter int READ_LAT     = 1
)(
   input logic                                   clk_i,
   input logic                                   rst_i,
   input logic                                   vsync_i,
   input logic                                   rd_en_i,
   input logic                                   rd_valid_o,
   input logic [NUM_WIN*REGS_PER_WIN*DATA_W-1:0] act_regs_o,
   input logic [NUM_WIN-1:0]                     act_en_o,
   input logic [NUM_WIN*REGS_PER_WIN*DATA_W-1:0] shadow_all,
   input logic [NUM_WIN-1:0]                     prot_q,
   input logic [NUM_WIN-1:0]                     pend_q,
   input logic                                   trig_we
);
   localparam int WIN_W = REGS_PER_WIN * DATA_W;

   AST_RESET_EMPTY: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> (act_en_o == '0 && prot_q == '0 && pend_q == '0)); // R1

   AST_HOLD_NO_VSYNC: assert property (@(posedge clk_i) disable iff (rst_i)
      !vsync_i |=> $stable(act_regs_o)); // R4

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_w
      AST_COPY_SHADOW: assert property (@(posedge clk_i) disable iff (rst_i)
         (vsync_i && pend_q[w] && !prot_q[w]) |=>
         act_regs_o[w*WIN_W +: WIN_W] == $past(shadow_all[w*WIN_W +: WIN_W])); // R3

      AST_PROT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
         (vsync_i && prot_q[w]) |=> $stable(act_regs_o[w*WIN_W +: WIN_W])); // R5

      AST_PROT_KEEPS_PEND: assert property (@(posedge clk_i) disable iff (rst_i)
         (vsync_i && prot_q[w] && pend_q[w]) |=> pend_q[w]); // R5

      AST_PEND_RETIRE: assert property (@(posedge clk_i) disable iff (rst_i)
         (vsync_i && pend_q[w] && !prot_q[w] && !trig_we) |=> !pend_q[w]); // R8
   end

   if (READ_LAT == 1) begin : g_rd
      AST_RD_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
         rd_en_i |=> rd_valid_o); // R2
   end
endmodule

bind vsync_shadow_regs vsr_checker #(
   .NUM_WIN(NUM_WIN), .REGS_PER_WIN(REGS_PER_WIN),
   .DATA_W(DATA_W), .READ_LAT(READ_LAT)
) u_chk (
   .clk_i      (clk_i),
   .rst_i      (rst_i),
   .vsync_i    (vsync_i),
   .rd_en_i    (rd_en_i),
   .rd_valid_o (rd_valid_o),
   .act_regs_o (act_regs_o),
   .act_en_o   (act_en_o),
   .shadow_all (shadow_all),
   .prot_q     (prot_q),
   .pend_q     (pend_q),
   .trig_we    (trig_we)
);

// File: tb/vsync_shadow_regs_tb.sv
`timescale 1ns/1ps
module vsync_shadow_regs_tb;
   localparam int NW = 2;
   localparam int RW = 4;
   localparam int DW = 32;
   localparam int AW = 4;
   localparam int TOT = NW * RW * DW;
   localparam int PROT_A = NW * RW;
   localparam int TRIG_A = PROT_A + 1;
   localparam int STAT_A = PROT_A + 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic wr_en = 1'b0, rd_en = 1'b0, vsync = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic rd_valid;
   logic [DW-1:0] rd_data;
   logic [TOT-1:0] act_regs;
   logic [NW-1:0] act_en;

   always #4 clk = ~clk;

   vsync_shadow_regs u_dut (
      .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
      .rd_valid_o(rd_valid), .rd_data_o(rd_data), .vsync_i(vsync),
      .act_regs_o(act_regs), .act_en_o(act_en)
   );

   // reference model
   logic [DW-1:0] m_sh [NW][RW];
   logic [DW-1:0] m_ac [NW][RW];
   logic [NW-1:0] m_prot, m_pend;
   logic          e_vld;
   logic [DW-1:0] e_dat;

   int errors = 0;
   int checks = 0;
   string cur_req = "R1";
   bit armed = 0;
   bit done = 0;

   function automatic logic [DW-1:0] model_read(input int a);
      logic [DW-1:0] r;
      r = '0;
      if (a < PROT_A) r = m_sh[a / RW][a % RW];
      else if (a == PROT_A) r = DW'(m_prot);
      else if (a == TRIG_A) r = DW'(m_pend);
      else if (a == STAT_A) begin
         for (int w = 0; w < NW; w++) r[w] = m_ac[w][0][0];
      end
      return r;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         for (int w = 0; w < NW; w++)
            for (int k = 0; k < RW; k++) begin
               m_sh[w][k] = '0;
               m_ac[w][k] = '0;
            end
         m_prot = '0;
         m_pend = '0;
         e_vld = 1'b0;
         e_dat = '0;
      end else begin
         logic [NW-1:0] np;
         e_vld = rd_en;
         if (rd_en) e_dat = model_read(int'(rd_addr));
         np = m_pend;
         for (int w = 0; w < NW; w++)
            if (vsync && m_pend[w] && !m_prot[w]) begin
               for (int k = 0; k < RW; k++) m_ac[w][k] = m_sh[w][k];
               np[w] = 1'b0;
            end
         if (wr_en) begin
            if (int'(wr_addr) < PROT_A) m_sh[int'(wr_addr) / RW][int'(wr_addr) % RW] = wr_data;
            else if (int'(wr_addr) == PROT_A) m_prot = wr_data[NW-1:0];
            else if (int'(wr_addr) == TRIG_A && wr_data[0]) np = '1;
         end
         m_pend = np;
      end
   end

   function automatic logic [TOT-1:0] model_flat();
      logic [TOT-1:0] f;
      for (int w = 0; w < NW; w++)
         for (int k = 0; k < RW; k++) f[(w*RW+k)*DW +: DW] = m_ac[w][k];
      return f;
   endfunction

   function automatic logic [NW-1:0] model_en();
      logic [NW-1:0] e;
      for (int w = 0; w < NW; w++) e[w] = m_ac[w][0][0];
      return e;
   endfunction

   task automatic chk(input string what, input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (armed) begin
         chk("act_regs", act_regs, model_flat());
         chk("act_en", TOT'(act_en), TOT'(model_en()));
         chk("rd_valid", TOT'(rd_valid), TOT'(e_vld));
         if (e_vld) chk("rd_data", TOT'(rd_data), TOT'(e_dat));
      end
   end

   task automatic step(input logic we, input int wa, input logic [DW-1:0] wd,
                       input logic re, input int ra, input logic vs);
      wr_en = we; wr_addr = AW'(wa); wr_data = wd;
      rd_en = re; rd_addr = AW'(ra); vsync = vs;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; vsync = 1'b0;
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d);
      step(1'b1, a, d, 1'b0, 0, 1'b0);
   endtask
   task automatic rd(input int a);
      step(1'b0, 0, '0, 1'b1, a, 1'b0);
   endtask
   task automatic vs();
      step(1'b0, 0, '0, 1'b0, 0, 1'b1);
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 0, '0, 1'b0, 0, 1'b0);
   endtask
   task automatic rd_all();
      for (int a = 0; a < 16; a++) rd(a);
      idle(1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      armed = 1;

      cur_req = "R1";
      checks++;
      if (act_en !== '0 || act_regs !== '0) begin
         errors++;
         $display("FAIL R1 reset: actual=%h/%h expected=0", act_en, act_regs);
      end
      rd_all();

      cur_req = "R2";
      for (int k = 0; k < RW; k++) wr(k, 32'hA000_0000 + k);
      rd_all();
      idle(3);

      cur_req = "R4";
      vs(); idle(1);
      rd(TRIG_A); idle(1);

      cur_req = "R8";
      wr(TRIG_A, 32'h0); rd(TRIG_A);
      wr(TRIG_A, 32'h1); rd(TRIG_A);
      cur_req = "R3";
      vs(); rd(TRIG_A); idle(1);

      cur_req = "R7";
      wr(RW, 32'h1); wr(TRIG_A, 1); vs(); rd(STAT_A); idle(1);
      wr(RW, 32'h0); idle(3); rd(STAT_A); idle(1);
      wr(TRIG_A, 1); vs(); rd(STAT_A); idle(1);

      cur_req = "R5";
      wr(PROT_A, 32'h1);
      wr(0, 32'hB0B0_0001); wr(1, 32'hB0B0_0002);
      wr(RW, 32'h0000_0011); wr(RW + 2, 32'hC0C0_0003);
      wr(TRIG_A, 1); vs(); rd(TRIG_A); idle(1);
      vs(); rd(TRIG_A); idle(1);
      cur_req = "R6";
      wr(PROT_A, 32'h0); idle(2); vs(); rd(TRIG_A); idle(1);

      cur_req = "R10";
      wr(TRIG_A, 1);
      step(1'b1, 1, 32'hDEAD_0010, 1'b0, 0, 1'b1);
      rd(1); idle(1);
      wr(TRIG_A, 1); vs(); idle(1);

      cur_req = "R11";
      step(1'b1, TRIG_A, 32'h1, 1'b0, 0, 1'b1);
      rd(TRIG_A); idle(1);
      wr(2, 32'h2222_2222); vs(); rd(TRIG_A); idle(1);

      cur_req = "R13";
      wr(3, 32'h3333_0003); wr(TRIG_A, 1);
      step(1'b1, PROT_A, 32'h3, 1'b0, 0, 1'b1);
      rd(PROT_A); rd(TRIG_A); idle(1);
      wr(RW + 3, 32'h4444_0004); wr(TRIG_A, 1);
      step(1'b1, PROT_A, 32'h0, 1'b0, 0, 1'b1);
      rd(TRIG_A); idle(1);

      cur_req = "R9";
      wr(0, 32'h1); wr(RW, 32'h1); wr(TRIG_A, 1); vs(); rd(STAT_A); idle(1);

      cur_req = "R12";
      for (int a = STAT_A; a < 16; a++) wr(a, 32'hFFFF_FFFF);
      rd_all();
      vs(); rd_all();

      cur_req = "R3";
      for (int i = 0; i < 400; i++) begin
         step(($urandom % 2) == 0, int'($urandom % 16), $urandom,
              ($urandom % 2) == 0, int'($urandom % 16), ($urandom % 4) == 0);
      end
      idle(2);

      done = 1;
      armed = 0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule